// File: doc/BRIEF.md
# Peripheral Autopoll Scheduler

This block decides when the devices on a serial peripheral bus are polled. While polling is enabled, a millisecond period timer counts down the configured period. When it expires the block raises a poll request towards the bus side, together with a 16-bit mask of the devices to poll. It then waits for the response. A response that carries data is turned into an outgoing packet: two header bytes, 0x00 and then a 0x40 byte that marks the data as polled, followed by the returned bytes. A response without data produces no packet. In both cases the next poll is planned one full period after the transaction completes.

The command processor writes the configuration: the enable argument, the period in milliseconds and the device mask. Each has its own write strobe. The enable acts on changes only. Switching it on starts a fresh period and switching it off cancels the pending one. Writing a new nonzero rate while polling is active restarts the period with the new value. A poll that comes due while the packet output path reports busy is held back until the path is free. The millisecond tick is derived from the `CLK_HZ` parameter.

Top module: `apoll_sched`

## Requirements
- R1: After reset, polling is disabled, the period is 20 ms, no poll request is raised and no packet byte is valid.
- R2: A nonzero enable argument written while disabled turns polling on, and `poll_req` goes high exactly `rate * CLK_HZ/1000` clock edges after the edge that samples the write.
- R3: A nonzero enable argument written while polling is already on leaves the running period untouched.
- R4: A zero enable argument written while polling is on, with no bus transaction open, cancels the period, and no poll request follows.
- R5: A nonzero rate written while polling is on and no bus transaction is open restarts the period with the new value from the sampling edge. A rate of zero is ignored, and the running period continues unchanged.
- R6: `poll_mask` is 0xFFFF after reset, takes the value of `mask_arg` on a `mask_wr` edge, and holds it otherwise.
- R7: `poll_req` stays high until `poll_ack` is sampled. A response with `poll_len` of 0 produces no packet.
- R8: A response with N data bytes (N >= 1, bytes taken from `poll_data` low byte first, capped at `MAX_BYTES`) produces N+2 consecutive valid bytes 0x00, 0x40, data[0] .. data[N-1], with `out_last` high on the final byte only.
- R9: After a transaction the next `poll_req` rises one period after its completion edge. The completion edge is the edge that samples `poll_ack` for an empty response, or the edge after the last packet byte.
- R10: A poll that comes due while `tx_busy` is high is deferred. `poll_req` rises at the first edge that samples `tx_busy` low.
- R11: A rate write or a disable write sampled on the same edge as the period expiry takes priority over the expiry. No poll is issued on that edge.
- R12: Disabling while a bus transaction is open still delivers its packet, and no later poll follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_wr | input | 1 | Enable argument write strobe |
| en_arg | input | 8 | Enable argument; nonzero means on |
| rate_wr | input | 1 | Period write strobe |
| rate_arg | input | 8 | Poll period in milliseconds |
| mask_wr | input | 1 | Device mask write strobe |
| mask_arg | input | 16 | Device mask value |
| tx_busy | input | 1 | Packet output path busy; defers a due poll |
| poll_req | output | 1 | Poll request towards the bus side |
| poll_mask | output | 16 | Devices to poll |
| poll_ack | input | 1 | Poll response present |
| poll_len | input | LEN_W | Number of returned data bytes |
| poll_data | input | 8*MAX_BYTES | Returned data, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Packet byte valid |
| out_byte | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
Period expiry can coincide with a configuration write. A rate write or a disable write sampled on the very edge where the millisecond count runs out must win over the poll. The bench counts clock edges from the enable write and places the strobe so that it is sampled on the expiry edge. It then checks that `poll_req` stays low on that edge. For the rate case, the next request must come exactly one new period later. For the disable case, no request may come at all.

// File: rtl/apoll_pkg.sv
package apoll_pkg;

    typedef enum logic [2:0] {
        AP_OFF,
        AP_RUN,
        AP_WAIT,
        AP_BUS,
        AP_SEND
    } ap_state_e;

    typedef struct packed {
        ap_state_e   st;
        logic        en;
        logic [7:0]  rate;
        logic [15:0] mask;
        logic [7:0]  ms;
    } ap_ctl_t;

endpackage

// File: rtl/apoll_tick.sv
module apoll_tick #(
    parameter int CLK_HZ = 50_000_000,
    parameter int MS_HZ  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int TICKS = (CLK_HZ / MS_HZ > 0) ? CLK_HZ / MS_HZ : 1;
    localparam int W     = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [W-1:0] pre_d, pre_q;

    assign tick = run && (pre_q == W'(TICKS - 1));

    always_comb begin
        pre_d = pre_q;
        if (clr) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = tick ? '0 : pre_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/apoll_framer.sv
module apoll_framer #(
    parameter int         MAX_BYTES = 8,
    parameter logic [7:0] HDR_KIND  = 8'h00,
    parameter logic [7:0] HDR_MARK  = 8'h40,
    parameter int         LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [LEN_W-1:0]       load_len,
    input  logic [8*MAX_BYTES-1:0] load_data,
    output logic                   out_valid,
    output logic [7:0]             out_byte,
    output logic                   out_last
);
    localparam int IW = $clog2(MAX_BYTES + 2);

    typedef struct packed {
        logic                   busy;
        logic [IW-1:0]          idx;
        logic [LEN_W-1:0]       len;
        logic [8*MAX_BYTES-1:0] data;
    } fr_t;

    fr_t d, q;

    assign out_valid = q.busy;
    assign out_last  = q.busy && (q.idx == IW'(q.len) + IW'(1));

    always_comb begin
        if (q.idx == '0)          out_byte = HDR_KIND;
        else if (q.idx == IW'(1)) out_byte = HDR_MARK;
        else                      out_byte = q.data[7:0];
    end

    always_comb begin
        d = q;
        if (load) begin
            d.busy = 1'b1;
            d.idx  = '0;
            d.len  = load_len;
            d.data = load_data;
        end else if (q.busy) begin
            if (out_last) begin
                d.busy = 1'b0;
            end else begin
                d.idx = q.idx + IW'(1);
                if (q.idx >= IW'(2)) d.data = q.data >> 8;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/apoll_sched.sv
module apoll_sched
    import apoll_pkg::*;
#(
    parameter int          CLK_HZ    = 50_000_000,
    parameter int          MAX_BYTES = 8,
    parameter logic [7:0]  DEF_RATE  = 8'd20,
    parameter logic [15:0] DEF_MASK  = 16'hFFFF,
    parameter int          LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_wr,
    input  logic [7:0]             en_arg,
    input  logic                   rate_wr,
    input  logic [7:0]             rate_arg,
    input  logic                   mask_wr,
    input  logic [15:0]            mask_arg,
    input  logic                   tx_busy,
    output logic                   poll_req,
    output logic [15:0]            poll_mask,
    input  logic                   poll_ack,
    input  logic [LEN_W-1:0]       poll_len,
    input  logic [8*MAX_BYTES-1:0] poll_data,
    output logic                   out_valid,
    output logic [7:0]             out_byte,
    output logic                   out_last
);
    ap_ctl_t          d, q;
    logic             tick, restart, fin, fr_load;
    logic             en_rise, en_fall, idle_ph, rate_ok;
    logic [7:0]       rate_n;
    logic [LEN_W-1:0] len_cap;

    assign len_cap = (poll_len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : poll_len;

    apoll_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st == AP_RUN),
        .clr  (restart),
        .tick (tick)
    );

    apoll_framer #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fr_load),
        .load_len (len_cap),
        .load_data(poll_data),
        .out_valid(out_valid),
        .out_byte (out_byte),
        .out_last (out_last)
    );

    always_comb begin
        d       = q;
        restart = 1'b0;
        fin     = 1'b0;
        fr_load = 1'b0;

        rate_ok = rate_wr && (rate_arg != 8'd0);
        rate_n  = rate_ok ? rate_arg : q.rate;
        en_rise = en_wr && (en_arg != 8'd0) && !q.en;
        en_fall = en_wr && (en_arg == 8'd0) && q.en;
        idle_ph = (q.st == AP_RUN) || (q.st == AP_WAIT);

        if (rate_ok) d.rate = rate_arg;
        if (mask_wr) d.mask = mask_arg;
        if (en_wr)   d.en   = (en_arg != 8'd0);

        // transaction progress
        case (q.st)
            AP_RUN: begin
                if (tick) begin
                    if (q.ms <= 8'd1) d.st = tx_busy ? AP_WAIT : AP_BUS;
                    else              d.ms = q.ms - 8'd1;
                end
            end
            AP_WAIT: begin
                if (!tx_busy) d.st = AP_BUS;
            end
            AP_BUS: begin
                if (poll_ack) begin
                    if (len_cap == '0) begin
                        fin = 1'b1;
                    end else begin
                        fr_load = 1'b1;
                        d.st    = AP_SEND;
                    end
                end
            end
            AP_SEND: begin
                if (out_last) fin = 1'b1;
            end
            default: ;
        endcase

        if (fin) begin
            d.st    = d.en ? AP_RUN : AP_OFF;
            restart = d.en;
        end

        // configuration writes override an expiry in the same cycle
        if (en_rise && (q.st == AP_OFF)) begin
            d.st    = AP_RUN;
            restart = 1'b1;
        end
        if (en_fall && idle_ph) begin
            d.st = AP_OFF;
        end
        if (rate_ok && q.en && !en_fall && idle_ph) begin
            d.st    = AP_RUN;
            restart = 1'b1;
        end

        if (restart) d.ms = rate_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= AP_OFF;
            q.en   <= 1'b0;
            q.rate <= DEF_RATE;
            q.mask <= DEF_MASK;
            q.ms   <= DEF_RATE;
        end else begin
            q <= d;
        end
    end

    assign poll_req  = (q.st == AP_BUS);
    assign poll_mask = q.mask;
endmodule

// File: rtl/apoll_sched_chk.sv
module apoll_sched_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_busy,
    input logic             poll_req,
    input logic             poll_ack,
    input logic [LEN_W-1:0] poll_len,
    input logic [15:0]      poll_mask,
    input logic             mask_wr,
    input logic             out_valid,
    input logic [7:0]       out_byte,
    input logic             out_last
);
    AST_REQ_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poll_req) |-> $past(!tx_busy)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req && !poll_ack |=> poll_req); // R7

    AST_EMPTY_NO_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req && poll_ack && (poll_len == '0) |=> !out_valid); // R7

    AST_HDR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_byte == 8'h00) && !out_last); // R8

    AST_HDR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |=> out_valid && (out_byte == 8'h40) && !out_last); // R8

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid); // R8

    AST_NO_REQ_DURING_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !poll_req); // R12

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(poll_mask)); // R6
endmodule

bind apoll_sched apoll_sched_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_busy  (tx_busy),
    .poll_req (poll_req),
    .poll_ack (poll_ack),
    .poll_len (poll_len),
    .poll_mask(poll_mask),
    .mask_wr  (mask_wr),
    .out_valid(out_valid),
    .out_byte (out_byte),
    .out_last (out_last)
);

// File: tb/test_apoll_sched.sv
module test_apoll_sched;
    localparam int CLK_HZ = 4000;
    localparam int TICKS  = CLK_HZ / 1000;
    localparam int MAXB   = 8;
    localparam int LW     = $clog2(MAXB + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en_wr = 1'b0, rate_wr = 1'b0, mask_wr = 1'b0;
    logic [7:0]      en_arg = '0, rate_arg = '0;
    logic [15:0]     mask_arg = '0;
    logic            tx_busy = 1'b0;
    logic            poll_req, poll_ack = 1'b0;
    logic [15:0]     poll_mask;
    logic [LW-1:0]   poll_len = '0;
    logic [8*MAXB-1:0] poll_data = '0;
    logic            out_valid, out_last;
    logic [7:0]      out_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    apoll_sched #(.CLK_HZ(CLK_HZ), .MAX_BYTES(MAXB)) i_apoll_sched (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_arg(en_arg),
        .rate_wr(rate_wr), .rate_arg(rate_arg),
        .mask_wr(mask_wr), .mask_arg(mask_arg),
        .tx_busy(tx_busy),
        .poll_req(poll_req), .poll_mask(poll_mask),
        .poll_ack(poll_ack), .poll_len(poll_len), .poll_data(poll_data),
        .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_en(input logic [7:0] v);
        en_wr = 1'b1; en_arg = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic cfg_rate(input logic [7:0] v);
        rate_wr = 1'b1; rate_arg = v;
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    task automatic measure(output int n, output bit saw_out);
        n = 0; saw_out = 1'b0;
        while (!poll_req && n < 2000) begin
            if (out_valid) saw_out = 1'b1;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic respond(input int len, input logic [8*MAXB-1:0] data);
        poll_ack = 1'b1; poll_len = LW'(len); poll_data = data;
        @(negedge clk);
        poll_ack = 1'b0; poll_len = '0; poll_data = '0;
    endtask

    task automatic collect(input int len, input logic [8*MAXB-1:0] data, input string req);
        for (int i = 0; i < len + 2; i++) begin
            logic [7:0] e;
            e = (i == 0) ? 8'h00 : (i == 1) ? 8'h40 : data[8*(i-2) +: 8];
            chk(out_valid && out_byte == e, req, int'(out_byte), int'(e));
            chk(out_last == (i == len + 1), req, int'(out_last), int'(i == len + 1));
            @(negedge clk);
        end
        chk(!out_valid, req, int'(out_valid), 0);
    endtask

    task automatic quiet(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            if (poll_req) seen++;
            @(negedge clk);
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset;
        chk(!poll_req && !out_valid, "R1", int'(poll_req), 0);
        chk(poll_mask == 16'hFFFF, "R6", int'(poll_mask), 16'hFFFF);
        quiet(100, "R1");
    endtask

    task automatic t_mask;
        mask_wr = 1'b1; mask_arg = 16'h1234;
        @(negedge clk);
        mask_wr = 1'b0; mask_arg = 16'hFFFF;
        chk(poll_mask == 16'h1234, "R6", int'(poll_mask), 16'h1234);
        repeat (5) @(negedge clk);
        chk(poll_mask == 16'h1234, "R6", int'(poll_mask), 16'h1234);
    endtask

    task automatic t_default_rate;
        int n; bit s;
        cfg_en(8'd1);
        measure(n, s);
        chk(n == 20 * TICKS, "R2", n, 20 * TICKS);
        repeat (3) @(negedge clk);
        chk(poll_req == 1'b1, "R7", int'(poll_req), 1);
        respond(0, '0);
        measure(n, s);
        chk(n == 20 * TICKS, "R9", n, 20 * TICKS);
        chk(!s, "R7", int'(s), 0);
        respond(0, '0);
        cfg_en(8'd0);
        quiet(120, "R4");
    endtask

    task automatic t_packet;
        int n; bit s;
        cfg_rate(8'd2);
        cfg_en(8'd1);
        measure(n, s);
        chk(n == 2 * TICKS, "R2", n, 2 * TICKS);
        respond(3, 64'h0000_0000_0033_2211);
        collect(3, 64'h0000_0000_0033_2211, "R8");
        measure(n, s);
        chk(n == 2 * TICKS, "R9", n, 2 * TICKS);
        respond(12, 64'h8877_6655_4433_2211);
        collect(8, 64'h8877_6655_4433_2211, "R8");
        measure(n, s);
        respond(0, '0);
        cfg_en(8'd0);
    endtask

    task automatic t_rate_write;
        int n; bit s;
        cfg_rate(8'd3);
        cfg_en(8'd1);
        repeat (3) @(negedge clk);
        cfg_rate(8'd2);
        measure(n, s);
        chk(n == 2 * TICKS, "R5", n, 2 * TICKS);
        respond(0, '0);
        cfg_en(8'd0);
        cfg_rate(8'd3);
        cfg_en(8'd1);
        repeat (3) @(negedge clk);
        cfg_rate(8'd0);
        measure(n, s);
        chk(n == 3 * TICKS - 4, "R5", n, 3 * TICKS - 4);
        respond(0, '0);
        cfg_en(8'd0);
    endtask

    task automatic t_same_enable;
        int n; bit s;
        cfg_en(8'd1);
        repeat (3) @(negedge clk);
        cfg_en(8'd7);
        measure(n, s);
        chk(n == 3 * TICKS - 4, "R3", n, 3 * TICKS - 4);
        respond(0, '0);
        cfg_en(8'd0);
    endtask

    task automatic t_collide;
        int n; bit s;
        cfg_rate(8'd2);
        cfg_en(8'd1);
        repeat (2 * TICKS - 1) @(negedge clk);
        cfg_rate(8'd3);
        chk(!poll_req, "R11", int'(poll_req), 0);
        measure(n, s);
        chk(n == 3 * TICKS, "R11", n, 3 * TICKS);
        respond(0, '0);
        cfg_en(8'd0);
        cfg_en(8'd1);
        repeat (3 * TICKS - 1) @(negedge clk);
        cfg_en(8'd0);
        chk(!poll_req, "R11", int'(poll_req), 0);
        quiet(60, "R11");
    endtask

    task automatic t_busy;
        int n; bit s;
        tx_busy = 1'b1;
        cfg_en(8'd1);
        repeat (3 * TICKS + 2) @(negedge clk);
        chk(!poll_req, "R10", int'(poll_req), 0);
        tx_busy = 1'b0;
        @(negedge clk);
        chk(poll_req, "R10", int'(poll_req), 1);
        respond(0, '0);
        cfg_en(8'd0);
    endtask

    task automatic t_disable_in_bus;
        int n; bit s;
        cfg_en(8'd1);
        measure(n, s);
        cfg_en(8'd0);
        chk(poll_req, "R12", int'(poll_req), 1);
        respond(2, 64'h0000_0000_0000_BEEF);
        collect(2, 64'h0000_0000_0000_BEEF, "R12");
        quiet(80, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_rate();
        t_mask();
        t_packet();
        t_rate_write();
        t_same_enable();
        t_collide();
        t_busy();
        t_disable_in_bus();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule